// File: doc/BRIEF.md
# Shared-Line Conversion-Ready Detector

Some sigma-delta converters use one output wire for two jobs. During a transfer it carries serial read data. Between transfers it also tells the host that a new conversion result is waiting. This block sits between an SPI controller and the converter's pins. Clock, outgoing data, the outgoing-data tristate control and every chip-select line pass from the controller side to the pin side. The converter's data-out line passes back the other way. Both directions are plain wires with no registers.

Alongside that path, the block watches three things: one chosen chip-select line, an activity flag from the controller, and the shared data-out line. Chip-select is active low, and the converter signals ready by pulling the shared line low.

A saturating counter measures how long the converter has been continuously selected while the controller is idle. The count guards against false detection while the converter's output settles after selection or after the last clock edge. Once the counter reaches its limit, a synchronized low level on the shared line drives a registered, level-type ready output. The output can feed an interrupt input or a hardware block that starts the read transfer.

Top module: `rdy_spi_monitor`

## Requirements
- R1: `pin_sclk_o`, `pin_mosi_o`, `pin_mosi_hiz_o` and every bit of `pin_csn_o` equal `ctl_sclk_i`, `ctl_mosi_i`, `ctl_mosi_hiz_i` and `ctl_csn_i` in the same cycle, with no register in between.
- R2: `ctl_miso_o` equals `pin_miso_i` in the same cycle, with no register in between.
- R3: While `rst_n` is low at a clock edge, `rdy_o` is 0 and the settle window restarts from zero. Once `rst_n` rises, a complete new window is needed before `rdy_o` can be 1.
- R4: A window starts at the first rising clock edge where `ctl_csn_i[CS_SEL]` is 0 and `ctl_busy_i` is 0. If both stay that way and `pin_miso_i` is 0, `rdy_o` is still 0 after edge SETTLE_CYCLES of the window and becomes 1 after edge SETTLE_CYCLES+1.
- R5: `rdy_o` is a level, not a pulse. It stays 1 for as long as the conditions in R4 hold, however long that is, because the settle counter saturates and never wraps.
- R6: If `ctl_csn_i[CS_SEL]` is 1 at a clock edge, `rdy_o` is 0 after that edge. The settle window then restarts from zero.
- R7: If `ctl_busy_i` is 1 at a clock edge, `rdy_o` is 0 after that edge. The settle window then restarts from zero.
- R8: `pin_miso_i` reaches the ready logic through a SYNC_STAGES-flop synchronizer (2 by default). When the line goes high, `rdy_o` falls after the third clock edge. When it returns low, `rdy_o` rises again after the third edge, with no new settle window.
- R9: Chip-select lines other than `ctl_csn_i[CS_SEL]` have no effect on `rdy_o` or on the settle window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ctl_busy_i | input | 1 | Controller transfer-in-progress flag |
| ctl_sclk_i | input | 1 | Serial clock from the controller |
| ctl_mosi_i | input | 1 | Outgoing serial data from the controller |
| ctl_mosi_hiz_i | input | 1 | Tristate control for outgoing data, from the controller |
| ctl_csn_i | input | CS_WIDTH | Active-low chip-selects from the controller |
| ctl_miso_o | output | 1 | Incoming serial data returned to the controller |
| pin_sclk_o | output | 1 | Serial clock to the pins |
| pin_mosi_o | output | 1 | Outgoing serial data to the pins |
| pin_mosi_hiz_o | output | 1 | Tristate control for outgoing data, to the pins |
| pin_csn_o | output | CS_WIDTH | Active-low chip-selects to the pins |
| pin_miso_i | input | 1 | Shared data-out and ready line from the converter |
| rdy_o | output | 1 | Conversion ready, active-high level |

## Verification
A clean idle window is checked one edge before and one edge after the ready rise. This separates a correct limit from an off-by-one count. The window is interrupted in three ways: by chip-select, by the busy flag, and by a break just short of the limit. Each interruption must force a full new count, which shows the counter is cleared rather than paused. The shared line is toggled inside a saturated window, and the bench expects a three-edge delay with no recount; this separates the synchronized path from the counter path. A long hold shows saturation rather than wrap-around, and toggling a different chip-select line shows it is ignored.

// File: rtl/rsm_pkg.sv
package rsm_pkg;

   // Outgoing controller signals that are forwarded to the pins.
   typedef struct packed {
      logic sclk;
      logic mosi;
      logic mosi_hiz;
   } rsm_drive_t;

   // Number of bits needed to hold values 0..limit.
   function automatic int unsigned cnt_bits(input int unsigned limit);
      int unsigned b;
      b = 1;
      while ((1 << b) <= limit) b++;
      return b;
   endfunction

endpackage

// File: rtl/rsm_passthru.sv
module rsm_passthru
   import rsm_pkg::*;
#(
   parameter int unsigned CS_WIDTH = 1
) (
   input  rsm_drive_t          drv_i,
   input  logic [CS_WIDTH-1:0] csn_i,
   input  logic                miso_i,
   output rsm_drive_t          drv_o,
   output logic [CS_WIDTH-1:0] csn_o,
   output logic                miso_o
);

   assign drv_o = drv_i;

   // One wire per chip-select line.
   for (genvar g = 0; g < CS_WIDTH; g++) begin : g_cs
      assign csn_o[g] = csn_i[g];
   end

   assign miso_o = miso_i;

endmodule

// File: rtl/rsm_sync.sv
module rsm_sync #(
   parameter int unsigned STAGES  = 2,
   parameter logic        RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);

   initial begin
      assert (STAGES >= 2)
         else $error("rsm_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain_q;

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk) begin
            if (!rst_n) chain_q[0] <= RST_VAL;
            else        chain_q[0] <= d_i;
         end
      end else begin : g_next
         always_ff @(posedge clk) begin
            if (!rst_n) chain_q[s] <= RST_VAL;
            else        chain_q[s] <= chain_q[s-1];
         end
      end
   end

   assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/rsm_idle_timer.sv
module rsm_idle_timer
   import rsm_pkg::*;
#(
   parameter int unsigned LIMIT = 63,
   localparam int unsigned CNT_W = cnt_bits(LIMIT)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic             full_o
);

   localparam logic [CNT_W-1:0] TOP = CNT_W'(LIMIT);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n)            cnt_q <= '0;
      else if (clear_i)      cnt_q <= '0;
      else if (cnt_q != TOP) cnt_q <= cnt_q + 1'b1;
   end

   assign cnt_o  = cnt_q;
   assign full_o = (cnt_q == TOP);

   // R5: a full counter stays full while the window is kept open.
   a_r5_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (full_o && !clear_i) |=> full_o);

   // R6 and R7: any break of the window drops the count to zero.
   a_r6_clear_restart: assert property (@(posedge clk) disable iff (!rst_n)
      clear_i |=> (cnt_o == '0));

   // R4: the count rises by exactly one per open cycle below the limit.
   a_r4_count_step: assert property (@(posedge clk) disable iff (!rst_n)
      (!clear_i && !full_o) |=> (cnt_o == $past(cnt_o) + 1'b1));

endmodule

// File: rtl/rdy_spi_monitor.sv
module rdy_spi_monitor
   import rsm_pkg::*;
#(
   parameter int unsigned CS_WIDTH      = 1,
   parameter int unsigned CS_SEL        = 0,
   parameter int unsigned SETTLE_CYCLES = 63,
   parameter int unsigned SYNC_STAGES   = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                ctl_busy_i,
   input  logic                ctl_sclk_i,
   input  logic                ctl_mosi_i,
   input  logic                ctl_mosi_hiz_i,
   input  logic [CS_WIDTH-1:0] ctl_csn_i,
   output logic                ctl_miso_o,
   output logic                pin_sclk_o,
   output logic                pin_mosi_o,
   output logic                pin_mosi_hiz_o,
   output logic [CS_WIDTH-1:0] pin_csn_o,
   input  logic                pin_miso_i,
   output logic                rdy_o
);

   localparam int unsigned CNT_W = cnt_bits(SETTLE_CYCLES);

   initial begin
      assert (CS_WIDTH >= 1)
         else $error("rdy_spi_monitor: CS_WIDTH must be at least 1");
      assert (CS_SEL < CS_WIDTH)
         else $error("rdy_spi_monitor: CS_SEL is out of range");
      assert (SETTLE_CYCLES >= 1)
         else $error("rdy_spi_monitor: SETTLE_CYCLES must be at least 1");
      assert (SYNC_STAGES >= 2)
         else $error("rdy_spi_monitor: SYNC_STAGES must be at least 2");
   end

   // Forwarding path between controller and pins.
   rsm_drive_t drv_in, drv_out;

   assign drv_in.sclk     = ctl_sclk_i;
   assign drv_in.mosi     = ctl_mosi_i;
   assign drv_in.mosi_hiz = ctl_mosi_hiz_i;

   rsm_passthru #(.CS_WIDTH(CS_WIDTH)) u_pass (
      .drv_i  (drv_in),
      .csn_i  (ctl_csn_i),
      .miso_i (pin_miso_i),
      .drv_o  (drv_out),
      .csn_o  (pin_csn_o),
      .miso_o (ctl_miso_o)
   );

   assign pin_sclk_o     = drv_out.sclk;
   assign pin_mosi_o     = drv_out.mosi;
   assign pin_mosi_hiz_o = drv_out.mosi_hiz;

   // Synchronized copy of the shared line; it idles high under reset.
   logic miso_s;

   rsm_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (pin_miso_i),
      .q_o   (miso_s)
   );

   // Settle window: counts cycles of selected and idle.
   logic             csn_sel;
   logic             win_break;
   logic [CNT_W-1:0] win_cnt;
   logic             win_full;

   assign csn_sel   = ctl_csn_i[CS_SEL];
   assign win_break = csn_sel | ctl_busy_i;

   rsm_idle_timer #(.LIMIT(SETTLE_CYCLES)) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear_i (win_break),
      .cnt_o   (win_cnt),
      .full_o  (win_full)
   );

   // Registered ready level.
   logic rdy_q;

   always_ff @(posedge clk) begin
      if (!rst_n) rdy_q <= 1'b0;
      else        rdy_q <= win_full & ~win_break & ~miso_s;
   end

   assign rdy_o = rdy_q;

   // R6: deselecting the converter drops ready on the next edge.
   a_r6_cs_drop: assert property (@(posedge clk) disable iff (!rst_n)
      csn_sel |=> !rdy_o);

   // R7: controller activity drops ready on the next edge.
   a_r7_busy_drop: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_busy_i |=> !rdy_o);

   // R4: ready is only reached from a full window.
   a_r4_needs_full: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rdy_o) |-> ($past(win_cnt) == CNT_W'(SETTLE_CYCLES)));

   // R8: a high synchronized line cannot coexist with a fresh ready.
   a_r8_line_high: assert property (@(posedge clk) disable iff (!rst_n)
      miso_s |=> !rdy_o);

endmodule

// File: tb/tb_rdy_spi_monitor.sv
module tb_rdy_spi_monitor;

   localparam int unsigned CSW = 2;
   localparam int unsigned SEL = 1;
   localparam int unsigned T   = 10;

   logic           clk = 1'b0;
   logic           rst_n;
   logic           busy, sclk, mosi, hiz, miso;
   logic [CSW-1:0] csn;
   logic           miso_back, p_sclk, p_mosi, p_hiz, rdy;
   logic [CSW-1:0] p_csn;

   int n_vec  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #2 clk = ~clk;

   rdy_spi_monitor #(
      .CS_WIDTH(CSW), .CS_SEL(SEL), .SETTLE_CYCLES(T), .SYNC_STAGES(2)
   ) dut (
      .clk(clk), .rst_n(rst_n), .ctl_busy_i(busy),
      .ctl_sclk_i(sclk), .ctl_mosi_i(mosi), .ctl_mosi_hiz_i(hiz),
      .ctl_csn_i(csn), .ctl_miso_o(miso_back),
      .pin_sclk_o(p_sclk), .pin_mosi_o(p_mosi), .pin_mosi_hiz_o(p_hiz),
      .pin_csn_o(p_csn), .pin_miso_i(miso), .rdy_o(rdy)
   );

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: got %0h expected %0h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
         $finish;
      end
   endtask

   // R1, R2: forwarding patterns, checked without any clock edge.
   task automatic t_passthru();
      for (int v = 0; v < 32; v++) begin
         {sclk, mosi, hiz, csn, miso} = 6'(v * 11);
         #0.5;
         chk("R1", {4'b0, p_sclk, p_mosi, p_hiz, 1'b0}, {4'b0, sclk, mosi, hiz, 1'b0});
         chk("R1", 8'(p_csn), 8'(csn));
         chk("R2", 8'(miso_back), 8'(miso));
      end
   endtask

   // R3: held in reset with the window open, then a clean start.
   task automatic t_reset_and_first();
      csn = 2'b01; busy = 0; miso = 0; sclk = 0; mosi = 0; hiz = 1;
      rst_n = 0;
      tick(T + 5);
      chk("R3", 8'(rdy), 8'd0);
      rst_n = 1;
      tick(T);
      chk("R4", 8'(rdy), 8'd0);
      tick(1);
      chk("R4", 8'(rdy), 8'd1);
   endtask

   // R5: long hold, beyond the counter's wrap point.
   task automatic t_hold();
      for (int i = 0; i < 40; i++) begin
         tick(1);
         chk("R5", 8'(rdy), 8'd1);
      end
   endtask

   // R6: deselect, then a full recount is needed.
   task automatic t_cs_break();
      csn[SEL] = 1;
      tick(1);
      chk("R6", 8'(rdy), 8'd0);
      csn[SEL] = 0;
      tick(T);
      chk("R6", 8'(rdy), 8'd0);
      tick(1);
      chk("R6", 8'(rdy), 8'd1);
   endtask

   // R7: one busy cycle forces a full recount.
   task automatic t_busy_break();
      busy = 1;
      tick(1);
      chk("R7", 8'(rdy), 8'd0);
      busy = 0;
      tick(T);
      chk("R7", 8'(rdy), 8'd0);
      tick(1);
      chk("R7", 8'(rdy), 8'd1);
   endtask

   // R8: line high, then low again, inside a saturated window.
   task automatic t_line();
      miso = 1;
      tick(2);
      chk("R8", 8'(rdy), 8'd1);
      tick(1);
      chk("R8", 8'(rdy), 8'd0);
      tick(5);
      miso = 0;
      tick(2);
      chk("R8", 8'(rdy), 8'd0);
      tick(1);
      chk("R8", 8'(rdy), 8'd1);
   endtask

   // R9: the other chip-select line is ignored.
   task automatic t_other_cs();
      for (int i = 0; i < 6; i++) begin
         csn[0] = ~csn[0];
         tick(1);
         chk("R9", 8'(rdy), 8'd1);
      end
      csn[SEL] = 1;
      csn[0] = 0;
      tick(T + 4);
      chk("R9", 8'(rdy), 8'd0);
      csn[SEL] = 0;
      csn[0] = 1;
      tick(T + 1);
      chk("R9", 8'(rdy), 8'd1);
   endtask

   // R4, R7: a break just short of the limit restarts the count.
   task automatic t_short_window();
      busy = 1;
      tick(1);
      busy = 0;
      tick(T - 2);
      busy = 1;
      tick(1);
      chk("R7", 8'(rdy), 8'd0);
      busy = 0;
      tick(T);
      chk("R4", 8'(rdy), 8'd0);
      tick(1);
      chk("R4", 8'(rdy), 8'd1);
   endtask

   // R3: reset taken while ready is high.
   task automatic t_reset_mid();
      rst_n = 0;
      tick(1);
      chk("R3", 8'(rdy), 8'd0);
      rst_n = 1;
      tick(T);
      chk("R3", 8'(rdy), 8'd0);
      tick(1);
      chk("R3", 8'(rdy), 8'd1);
   endtask

   initial begin
      rst_n = 0; busy = 0; sclk = 0; mosi = 0; hiz = 0; csn = '1; miso = 1;
      t_passthru();
      t_reset_and_first();
      t_hold();
      t_cs_break();
      t_busy_break();
      t_line();
      t_other_cs();
      t_short_window();
      t_reset_mid();
      finish_run();
   end

   initial begin
      #(4 * 200000);
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
   end

endmodule